// File: doc/BRIEF.md
# SDRAM Read Burst Data Pipeline

This block models the memory-side read data path of a single-data-rate synchronous DRAM. Each clock it takes one decoded command: idle, read (with bank, column and an auto-precharge flag), burst stop, or bank close. It returns read data on an output bus with a valid flag and a bank/column tag. Data leaves the block a programmed number of cycles (2 or 3) after the read that asked for it. A burst is either four words long or runs through the whole page until something stops it.

No storage array is modelled. The word returned for a location is that location's bank and column, zero-extended to the data width. A bench can therefore check ordering, interruption and latency directly from the output. A new read, a burst stop or a bank close all act on the data bus exactly one latency after they are issued. Words already inside the latency pipeline still come out.

Top module: `sdram_rd_pipe`

## Requirements
- R1: After reset, `dvalid_o` is 0 and `dout_o` is 0. The latency is 2 and the burst type is fixed-length until the first accepted mode load.
- R2: With latency 2 (`cfg_cl3_i`=0 when loaded), the first word of a read (`cmd_i`=1) is on the outputs in the cycle two clock edges after the edge that samples the read.
- R3: With latency 3 (`cfg_cl3_i`=1 when loaded), the first word appears three edges after the read edge.
- R4: In fixed mode (`cfg_full_i`=0), a read to column n returns columns n, n+1, n+2 and n+3 (modulo 2^COL_W) on consecutive cycles, with the same bank. `dvalid_o` then falls, unless another command has intervened.
- R5: In full-page mode (`cfg_full_i`=1), the column keeps incrementing and wraps from 2^COL_W-1 to 0 for as long as the burst is not interrupted.
- R6: A read issued while a burst is running replaces that burst. Its first word follows the last word of the old burst with no idle cycle.
- R7: Reads may be issued on every cycle to any bank and column. Each returns its first word one latency later, back to back.
- R8: A burst stop (`cmd_i`=2) on a full-page burst makes the word one latency minus one cycle after the stop edge the last valid one.
- R9: A burst stop on a fixed burst truncates it in the same way when that burst's read had `ap_i`=0. When the read had `ap_i`=1, the stop is ignored and all four words are delivered.
- R10: A bank close (`cmd_i`=3) whose `bank_i` equals the bank being read truncates the burst under the same timing as R8. A bank close to any other bank has no effect on the burst.
- R11: When `dvalid_o`=1, `dout_o` equals {`dbank_o`,`dcol_o`} zero-extended to DATA_W. When `dvalid_o`=0, `dout_o` is 0.
- R12: A mode load (`cfg_load_i`=1) is taken only when no burst is active, no data is in flight and no read is issued in that cycle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 0 idle, 1 read, 2 burst stop, 3 bank close |
| bank_i | input | BANK_W | Bank of a read or bank close |
| col_i | input | COL_W | Start column of a read |
| ap_i | input | 1 | Auto-precharge flag of a read |
| cfg_load_i | input | 1 | Request to load the mode fields |
| cfg_cl3_i | input | 1 | Latency select: 0 gives 2 cycles, 1 gives 3 |
| cfg_full_i | input | 1 | Burst type: 0 fixed four words, 1 full page |
| dvalid_o | output | 1 | Output carries a data word |
| dbank_o | output | BANK_W | Bank tag of the word |
| dcol_o | output | COL_W | Column tag of the word |
| dout_o | output | DATA_W | Data word |

## Verification
Two things can land on the data bus in the same cycle: the tail of a burst still in flight and the effect of an interrupting command. One case is a new read whose first word must follow the old burst's last word directly. The other is a stop or bank close whose empty slot must arrive after the old words already launched. The bench issues the interrupting command a few cycles into a burst, at both latencies, and records the output of every cycle by index. It then judges the exact cycle in which the old stream ends and the new word or idle slot begins. It also sends stops to auto-precharged bursts and bank closes to other banks, and confirms that the full burst still comes out.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_CLOSE = 2'd3
  } rd_cmd_e;

  localparam int FIXED_LEN = 4;
  localparam int LAT_MIN   = 2;
  localparam int LAT_MAX   = 3;

endpackage

// File: rtl/sdram_rd_mode.sv
module sdram_rd_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cl3_i,
  input  logic full_i,
  input  logic busy_i,
  output logic cl3_o,
  output logic full_o
);

  logic cl3_q, cl3_d;
  logic full_q, full_d;
  logic take;

  always_comb begin
    take   = load_i & ~busy_i;
    cl3_d  = cl3_q;
    full_d = full_q;
    if (take) begin
      cl3_d  = cl3_i;
      full_d = full_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl3_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (take) begin
      cl3_q  <= cl3_d;
      full_q <= full_d;
    end
  end

  assign cl3_o  = cl3_q;
  assign full_o = full_q;

endmodule

// File: rtl/sdram_rd_burst.sv
module sdram_rd_burst
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_cmd_e           cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic              full_mode_i,
  output logic              slot_vld_o,
  output logic [BANK_W-1:0] slot_bank_o,
  output logic [COL_W-1:0]  slot_col_o,
  output logic              active_o
);

  localparam int REM_W = $clog2(FIXED_LEN);
  localparam logic [REM_W-1:0] REM_START = REM_W'(FIXED_LEN - 1);
  localparam logic [REM_W-1:0] REM_LAST  = REM_W'(1);

  logic              act_q, act_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              full_q, full_d;
  logic              ap_q, ap_d;
  logic              advance;
  logic              stop_hit;

  // next-state: decide the word launched in this cycle's slot
  always_comb begin
    act_d       = act_q;
    bank_d      = bank_q;
    col_d       = col_q;
    rem_d       = rem_q;
    full_d      = full_q;
    ap_d        = ap_q;
    slot_vld_o  = 1'b0;
    slot_bank_o = bank_q;
    slot_col_o  = col_q;
    advance     = 1'b0;
    stop_hit    = 1'b0;

    unique case (cmd_i)
      CMD_READ: begin
        slot_vld_o  = 1'b1;
        slot_bank_o = bank_i;
        slot_col_o  = col_i;
        act_d       = 1'b1;
        bank_d      = bank_i;
        col_d       = COL_W'(col_i + COL_W'(1));
        rem_d       = REM_START;
        full_d      = full_mode_i;
        ap_d        = ap_i;
      end
      CMD_STOP: begin
        stop_hit = act_q & (full_q | ~ap_q);
        advance  = act_q & ~stop_hit;
      end
      CMD_CLOSE: begin
        stop_hit = act_q & (bank_i == bank_q);
        advance  = act_q & ~stop_hit;
      end
      default: begin
        advance = act_q;
      end
    endcase

    if (stop_hit) begin
      act_d = 1'b0;
    end

    if (advance) begin
      slot_vld_o = 1'b1;
      col_d      = COL_W'(col_q + COL_W'(1));
      if (!full_q) begin
        rem_d = rem_q - REM_W'(1);
        if (rem_q == REM_LAST) begin
          act_d = 1'b0;
        end
      end
    end
  end

  logic upd;
  assign upd = (cmd_i == CMD_READ) | advance | stop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      rem_q  <= '0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
    end else if (upd) begin
      act_q  <= act_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      rem_q  <= rem_d;
      full_q <= full_d;
      ap_q   <= ap_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/sdram_rd_delay.sv
module sdram_rd_delay #(
  parameter int W      = 10,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  input  logic         sel_long,
  output logic         out_vld,
  output logic [W-1:0] out_dat,
  output logic         busy_o
);

  localparam int DEPTH   = MAX_CL;
  localparam int TAP_SHT = MIN_CL - 1;
  localparam int TAP_LNG = MAX_CL - 1;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];
  logic             shift_en;

  always_comb begin
    vld_d[0] = in_vld;
    dat_d[0] = in_vld ? in_dat : '0;
    for (int s = 1; s < DEPTH; s++) begin
      vld_d[s] = vld_q[s-1];
      dat_d[s] = dat_q[s-1];
    end
    shift_en = in_vld | (|vld_q);
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else if (shift_en) begin
          vld_q[g] <= vld_d[g];
          dat_q[g] <= dat_d[g];
        end
      end
    end
  endgenerate

  assign out_vld = sel_long ? vld_q[TAP_LNG] : vld_q[TAP_SHT];
  assign out_dat = sel_long ? dat_q[TAP_LNG] : dat_q[TAP_SHT];
  assign busy_o  = |vld_q;

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic              cfg_load_i,
  input  logic              cfg_cl3_i,
  input  logic              cfg_full_i,
  output logic              dvalid_o,
  output logic [BANK_W-1:0] dbank_o,
  output logic [COL_W-1:0]  dcol_o,
  output logic [DATA_W-1:0] dout_o
);

  localparam int TAG_W = BANK_W + COL_W;

  rd_cmd_e           cmd;
  logic              cl3_w;
  logic              full_w;
  logic              busy_w;
  logic              gen_act;
  logic              pipe_busy;
  logic              slot_vld;
  logic [BANK_W-1:0] slot_bank;
  logic [COL_W-1:0]  slot_col;
  logic              tap_vld;
  logic [TAG_W-1:0]  tap_tag;

  assign cmd    = rd_cmd_e'(cmd_i);
  assign busy_w = gen_act | pipe_busy | (cmd == CMD_READ);

  sdram_rd_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cfg_load_i),
    .cl3_i  (cfg_cl3_i),
    .full_i (cfg_full_i),
    .busy_i (busy_w),
    .cl3_o  (cl3_w),
    .full_o (full_w)
  );

  sdram_rd_burst #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W)
  ) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .ap_i        (ap_i),
    .full_mode_i (full_w),
    .slot_vld_o  (slot_vld),
    .slot_bank_o (slot_bank),
    .slot_col_o  (slot_col),
    .active_o    (gen_act)
  );

  sdram_rd_delay #(
    .W      (TAG_W),
    .MIN_CL (LAT_MIN),
    .MAX_CL (LAT_MAX)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (slot_vld),
    .in_dat   ({slot_bank, slot_col}),
    .sel_long (cl3_w),
    .out_vld  (tap_vld),
    .out_dat  (tap_tag),
    .busy_o   (pipe_busy)
  );

  assign dvalid_o = tap_vld;
  assign dbank_o  = tap_tag[TAG_W-1:COL_W];
  assign dcol_o   = tap_tag[COL_W-1:0];
  assign dout_o   = {{(DATA_W - TAG_W){1'b0}}, tap_tag};

endmodule

// File: rtl/sdram_rd_chk.sv
module sdram_rd_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic [COL_W-1:0]  col_i,
  input logic              cl3,
  input logic              full_mode,
  input logic              busy,
  input logic              dvalid_o,
  input logic [BANK_W-1:0] dbank_o,
  input logic [COL_W-1:0]  dcol_o,
  input logic [DATA_W-1:0] dout_o
);

  localparam int TAG_W = BANK_W + COL_W;

  AST_READ_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd1 && !cl3) |-> ##2 (dvalid_o && dcol_o == $past(col_i, 2))); // R2

  AST_READ_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd1 && cl3) |-> ##3 (dvalid_o && dcol_o == $past(col_i, 3))); // R3

  AST_STOP_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd2 && full_mode && !cl3) |-> ##2 !dvalid_o); // R8

  AST_STOP_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd2 && full_mode && cl3) |-> ##3 !dvalid_o); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid_o |-> (dout_o == '0)); // R11

  AST_TAG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> (dout_o[TAG_W-1:0] == {dbank_o, dcol_o})); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cl3) && $stable(full_mode))); // R12

endmodule

bind sdram_rd_pipe sdram_rd_chk #(
  .BANK_W (BANK_W),
  .COL_W  (COL_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_i     (cmd_i),
  .col_i     (col_i),
  .cl3       (cl3_w),
  .full_mode (full_w),
  .busy      (busy_w),
  .dvalid_o  (dvalid_o),
  .dbank_o   (dbank_o),
  .dcol_o    (dcol_o),
  .dout_o    (dout_o)
);

// File: tb/tb_sdram_rd_pipe.sv
module tb_sdram_rd_pipe;

  localparam int PERIOD = 10;
  localparam int HIST   = 4096;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cmd;
  logic [1:0]  bank;
  logic [7:0]  col;
  logic        ap;
  logic        cfg_load;
  logic        cfg_cl3;
  logic        cfg_full;
  logic        dvalid;
  logic [1:0]  dbank;
  logic [7:0]  dcol;
  logic [31:0] dout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic        h_v [HIST];
  logic [1:0]  h_b [HIST];
  logic [7:0]  h_c [HIST];
  logic [31:0] h_d [HIST];

  sdram_rd_pipe dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .bank_i     (bank),
    .col_i      (col),
    .ap_i       (ap),
    .cfg_load_i (cfg_load),
    .cfg_cl3_i  (cfg_cl3),
    .cfg_full_i (cfg_full),
    .dvalid_o   (dvalid),
    .dbank_o    (dbank),
    .dcol_o     (dcol),
    .dout_o     (dout)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // capture outputs away from the rising edge
  always @(negedge clk) begin
    if (cyc < HIST) begin
      h_v[cyc] = dvalid;
      h_b[cyc] = dbank;
      h_c[cyc] = dcol;
      h_d[cyc] = dout;
    end
    cyc = cyc + 1;
  end

  // {latency3, bank, start column, expected column of the fourth word}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 2'd1, 8'h10, 8'h13},
    {1'b1, 2'd2, 8'h20, 8'h23},
    {1'b0, 2'd3, 8'hFE, 8'h01},
    {1'b1, 2'd0, 8'hFD, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h03},
    {1'b1, 2'd3, 8'hFF, 8'h02}
  };

  task automatic drive(input logic [1:0] c, input logic [1:0] b,
                       input logic [7:0] cl, input logic a, output int t);
    @(negedge clk);
    #1;
    cmd = c; bank = b; col = cl; ap = a; cfg_load = 1'b0;
    t = cyc - 1;
  endtask

  task automatic idle(input int n);
    int t;
    for (int i = 0; i < n; i++) drive(2'd0, 2'd0, 8'd0, 1'b0, t);
  endtask

  task automatic setmode(input logic l3, input logic fp);
    @(negedge clk);
    #1;
    cmd = 2'd0; cfg_load = 1'b1; cfg_cl3 = l3; cfg_full = fp;
  endtask

  task automatic chk(input string req, input int idx, input logic ev,
                     input logic [1:0] eb, input logic [7:0] ec);
    logic [31:0] ed;
    bit bad;
    ed  = ev ? {22'd0, eb, ec} : 32'd0;
    bad = (h_v[idx] !== ev) || (h_d[idx] !== ed) ||
          (ev && (h_b[idx] !== eb || h_c[idx] !== ec));
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s cycle %0d: valid=%0b bank=%0d col=%h dout=%h, expected valid=%0b bank=%0d col=%h dout=%h",
               req, idx, h_v[idx], h_b[idx], h_c[idx], h_d[idx], ev, eb, ec, ed);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0;
    int t1;
    int lat;
    rst_n = 1'b0; cmd = 2'd0; bank = 2'd0; col = 8'd0; ap = 1'b0;
    cfg_load = 1'b0; cfg_cl3 = 1'b0; cfg_full = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1 reset idle", 2, 1'b0, 2'd0, 8'd0);

    // R1: default latency 2, fixed burst
    drive(2'd1, 2'd2, 8'h44, 1'b0, t0);
    idle(9);
    chk("R1 default lat", t0 + 1, 1'b0, 2'd0, 8'd0);
    chk("R1 default lat", t0 + 2, 1'b1, 2'd2, 8'h44);
    chk("R1 default fixed", t0 + 5, 1'b1, 2'd2, 8'h47);
    chk("R1 default fixed", t0 + 6, 1'b0, 2'd0, 8'd0);

    // table walk: R2 R3 R4 R11
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c0;
      idle(6);
      setmode(VEC[v][18], 1'b0);
      idle(2);
      c0  = VEC[v][15:8];
      lat = VEC[v][18] ? 3 : 2;
      drive(2'd1, VEC[v][17:16], c0, 1'b0, t0);
      idle(8);
      chk(VEC[v][18] ? "R3 lat3 early" : "R2 lat2 early", t0 + lat - 1, 1'b0, 2'd0, 8'd0);
      chk(VEC[v][18] ? "R3 lat3 first" : "R2 lat2 first", t0 + lat, 1'b1, VEC[v][17:16], c0);
      for (int k = 1; k < 3; k++)
        chk("R4 fixed order", t0 + lat + k, 1'b1, VEC[v][17:16], 8'(c0 + k));
      chk("R4 fixed last R11", t0 + lat + 3, 1'b1, VEC[v][17:16], VEC[v][7:0]);
      chk("R4 fixed end", t0 + lat + 4, 1'b0, 2'd0, 8'd0);
    end

    // R5 R8: full page wrap then stop, latency 2
    idle(6); setmode(1'b0, 1'b1); idle(2);
    drive(2'd1, 2'd1, 8'hFD, 1'b0, t0);
    idle(5);
    drive(2'd2, 2'd0, 8'd0, 1'b0, t1);
    idle(8);
    for (int k = 0; k < 6; k++)
      chk("R5 full wrap", t0 + 2 + k, 1'b1, 2'd1, 8'(8'hFD + k));
    chk("R8 stop lat2", t1 + 2, 1'b0, 2'd0, 8'd0);

    // R8: stop at latency 3, in-flight words complete
    idle(6); setmode(1'b1, 1'b1); idle(2);
    drive(2'd1, 2'd2, 8'h30, 1'b0, t0);
    idle(2);
    drive(2'd2, 2'd0, 8'd0, 1'b0, t1);
    idle(8);
    chk("R8 inflight", t1 + 2, 1'b1, 2'd2, 8'h32);
    chk("R8 stop lat3", t1 + 3, 1'b0, 2'd0, 8'd0);

    // R6: read interrupts read, latency 2
    idle(6); setmode(1'b0, 1'b0); idle(2);
    drive(2'd1, 2'd0, 8'h40, 1'b0, t0);
    idle(1);
    drive(2'd1, 2'd3, 8'h80, 1'b0, t1);
    idle(8);
    chk("R6 old tail", t0 + 3, 1'b1, 2'd0, 8'h41);
    chk("R6 new head", t0 + 4, 1'b1, 2'd3, 8'h80);
    chk("R6 new last", t0 + 7, 1'b1, 2'd3, 8'h83);
    chk("R6 end", t0 + 8, 1'b0, 2'd0, 8'd0);

    // R7: reads every cycle, latency 3
    idle(6); setmode(1'b1, 1'b0); idle(2);
    drive(2'd1, 2'd0, 8'h05, 1'b0, t0);
    drive(2'd1, 2'd1, 8'h33, 1'b0, t1);
    drive(2'd1, 2'd2, 8'h9A, 1'b0, t1);
    drive(2'd1, 2'd3, 8'h11, 1'b0, t1);
    idle(10);
    chk("R7 word0", t0 + 3, 1'b1, 2'd0, 8'h05);
    chk("R7 word1", t0 + 4, 1'b1, 2'd1, 8'h33);
    chk("R7 word2", t0 + 5, 1'b1, 2'd2, 8'h9A);
    chk("R7 word3", t0 + 6, 1'b1, 2'd3, 8'h11);
    chk("R7 tail", t0 + 7, 1'b1, 2'd3, 8'h12);

    // R9: stop on fixed burst, without and with auto precharge, latency 2
    idle(6); setmode(1'b0, 1'b0); idle(2);
    drive(2'd1, 2'd1, 8'h60, 1'b0, t0);
    idle(1);
    drive(2'd2, 2'd0, 8'd0, 1'b0, t1);
    idle(8);
    chk("R9 trunc last", t0 + 3, 1'b1, 2'd1, 8'h61);
    chk("R9 trunc end", t0 + 4, 1'b0, 2'd0, 8'd0);
    drive(2'd1, 2'd1, 8'h60, 1'b1, t0);
    idle(1);
    drive(2'd2, 2'd0, 8'd0, 1'b0, t1);
    idle(8);
    chk("R9 ap ignores stop", t0 + 4, 1'b1, 2'd1, 8'h62);
    chk("R9 ap ignores stop", t0 + 5, 1'b1, 2'd1, 8'h63);
    chk("R9 ap end", t0 + 6, 1'b0, 2'd0, 8'd0);

    // R10: bank close, same and other bank, latency 3
    idle(6); setmode(1'b1, 1'b0); idle(2);
    drive(2'd1, 2'd2, 8'h70, 1'b0, t0);
    drive(2'd3, 2'd2, 8'd0, 1'b0, t1);
    idle(8);
    chk("R10 same bank head", t0 + 3, 1'b1, 2'd2, 8'h70);
    chk("R10 same bank cut", t0 + 4, 1'b0, 2'd0, 8'd0);
    drive(2'd1, 2'd2, 8'h70, 1'b0, t0);
    drive(2'd3, 2'd1, 8'd0, 1'b0, t1);
    idle(8);
    chk("R10 other bank", t0 + 4, 1'b1, 2'd2, 8'h71);
    chk("R10 other bank", t0 + 6, 1'b1, 2'd2, 8'h73);

    // R12: mode load while busy is ignored
    idle(6); setmode(1'b0, 1'b0); idle(2);
    drive(2'd1, 2'd0, 8'h10, 1'b0, t0);
    setmode(1'b1, 1'b1);
    idle(10);
    drive(2'd1, 2'd0, 8'h50, 1'b0, t1);
    idle(8);
    chk("R12 busy load ignored", t1 + 2, 1'b1, 2'd0, 8'h50);
    chk("R12 still fixed", t1 + 6, 1'b0, 2'd0, 8'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule